// File: doc/BRIEF.md
# Programmable Frame-Sync Generator

This block is the clocking master of a serial audio port. From a source clock it builds a bit clock and a periodic frame-sync pulse. The source is either the block's own system clock or an external clock pin, picked by a select input. The external pin is brought into the system clock domain through a synchronizer chain before use. A shifter beside the block takes single-cycle strobes that mark every rising and falling bit-clock edge, so it never has to look for edges itself.

The frame is set by two fields, each written as a count minus one. The period field gives the number of bit clocks per frame, less one. The width field gives the number of bit clocks the pulse stays asserted, less one. For left/right framing of two 16-bit words the fields are 31 and 15, which gives a half-frame pulse. Two enables bring the block up: the generator enable starts the bit clock, and the frame enable, raised after it, starts the pulses. Pulses repeat every period with no data write needed. The active level of the pulse can be set.

Top module: `frame_sync_gen`

## Requirements
- R1: While reset is held, the bit clock is low, both edge strobes are low, and the frame-sync pin sits at its inactive level: 0 when `fs_act_low_i` is 0, and 1 when it is 1.
- R2: With the internal source selected (`src_ext_i` = 0) and the generator enabled, `bclk_o` toggles on every system clock edge. `bclk_rise_o` is high exactly in the cycles where `bclk_o` has just gone from 0 to 1, and `bclk_fall_o` is high exactly where it has just gone from 1 to 0.
- R3: With the external source selected (`src_ext_i` = 1), `bclk_o` follows `ext_clk_i` three system clock edges later: two synchronizer stages plus the bit-clock register. One rising strobe is given per external clock period.
- R4: With `gen_en_i` low, `bclk_o` stays low and no edge strobes are given, apart from the single fall strobe when a high bit clock is stopped.
- R5: Pulses are produced only while both `gen_en_i` and `fs_en_i` are high. With the generator running alone, the frame-sync pin stays at its inactive level.
- R6: A period field of P gives a frame of P+1 bit clocks. The pulse pattern repeats every P+1 rising strobes.
- R7: A width field of W keeps the pulse active for W+1 bit clocks at the start of each frame. After the frame enable rises, the frame count starts at zero, so the first rising strobe after that begins a pulse.
- R8: A width field greater than or equal to the period field is clamped to P-1. A period field of 0 gives a pulse that is active on every bit clock.
- R9: The period and width fields are captured only in the cycle in which the combined enable (`gen_en_i` and `fs_en_i`) rises. Later changes to the fields have no effect until the next rise.
- R10: With `fs_act_low_i` = 1 the frame-sync pin is inverted: it is low while the pulse is active and high otherwise.
- R11: Dropping either enable clears the frame count and the pulse on the next edge, so the block returns to idle. Enabling again restarts the frame from count zero.
- R12: `fsync_o` changes on the system clock edge that follows the cycle in which `bclk_rise_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External source clock pin |
| src_ext_i | input | 1 | Source select: 0 internal clock, 1 external pin |
| gen_en_i | input | 1 | Bit-clock generator enable |
| fs_en_i | input | 1 | Frame-sync enable |
| fs_act_low_i | input | 1 | Frame-sync polarity: 1 makes the pulse active low |
| period_i | input | CNT_W | Bit clocks per frame minus one |
| width_i | input | CNT_W | Bit clocks of pulse minus one |
| bclk_o | output | 1 | Bit clock |
| bclk_rise_o | output | 1 | One-cycle strobe on each bit-clock rising edge |
| bclk_fall_o | output | 1 | One-cycle strobe on each bit-clock falling edge |
| fsync_o | output | 1 | Frame-sync pulse |

## Verification
A frame counter that starts from the wrong value, wraps at the wrong point or compares against a badly clamped width moves or resizes the pulse. That shows up on `fsync_o` within one frame, P+1 bit clocks, of the frame enable rising. Captured fields that do not hold their values change the pulse spacing on the first frame boundary after the input fields change. A lost start-of-frame clear shows as a missing pulse on the first rising strobe after the frame is re-enabled. A wrong bit-clock register or synchronizer depth breaks the strict toggle pattern, or the fixed three-edge lag behind the external pin, within a few cycles.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

   // Selects where the bit clock comes from
   typedef enum logic {
      SRC_INT = 1'b0,
      SRC_EXT = 1'b1
   } fsg_src_e;

   // Edge strobes handed to the shifter
   typedef struct packed {
      logic rise;
      logic fall;
   } fsg_edge_t;

endpackage

// File: rtl/fsg_clk_src.sv
module fsg_clk_src
   import fsg_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_clk_i,
   input  logic src_ext_i,
   input  logic bclk_cur_i,
   output logic lvl_next_o
);

   localparam int LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("fsg_clk_src: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
      end
   end

   fsg_src_e src_sel;
   assign src_sel = fsg_src_e'(src_ext_i);

   always_comb begin
      unique case (src_sel)
         SRC_EXT: lvl_next_o = sync_q[LAST];
         default: lvl_next_o = ~bclk_cur_i;
      endcase
   end

endmodule

// File: rtl/fsg_bclk.sv
module fsg_bclk
   import fsg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      gen_en_i,
   input  logic      lvl_next_i,
   output logic      bclk_o,
   output fsg_edge_t edge_o
);

   logic bclk_q;
   logic rise_q;
   logic fall_q;
   logic lvl_gated;

   assign lvl_gated = gen_en_i & lvl_next_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         bclk_q <= lvl_gated;
         rise_q <= lvl_gated & ~bclk_q;
         fall_q <= bclk_q & ~lvl_gated;
      end
   end

   assign bclk_o      = bclk_q;
   assign edge_o.rise = rise_q;
   assign edge_o.fall = fall_q;

   AST_BCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en_i |=> !bclk_q) else $error("bit clock runs while disabled"); // R4
   AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_q && fall_q)) else $error("rise and fall strobes together"); // R2
   AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |-> bclk_q) else $error("rise strobe with low bit clock"); // R2

endmodule

// File: rtl/fsg_frame.sv
module fsg_frame #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] width_i,
   output logic             active_o
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("fsg_frame: CNT_W must be at least 2");
      end
   endgenerate

   function automatic logic [CNT_W-1:0] clamp_width(input logic [CNT_W-1:0] per,
                                                    input logic [CNT_W-1:0] wid);
      if (per == '0)
         return '0;
      else if (wid >= per)
         return per - ONE;
      else
         return wid;
   endfunction

   logic             run_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] wid_q;
   logic [CNT_W-1:0] cnt_q;
   logic             act_q;
   logic             start;
   logic             wrap;

   assign start = run_i & ~run_q;
   assign wrap  = (cnt_q == per_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         per_q <= '0;
         wid_q <= '0;
         cnt_q <= '0;
         act_q <= 1'b0;
      end else begin
         run_q <= run_i;
         if (!run_i) begin
            cnt_q <= '0;
            act_q <= 1'b0;
         end else if (start) begin
            per_q <= period_i;
            wid_q <= clamp_width(period_i, width_i);
            cnt_q <= '0;
            act_q <= 1'b0;
         end else if (tick_i) begin
            act_q <= (cnt_q <= wid_q);
            cnt_q <= wrap ? '0 : cnt_q + ONE;
         end
      end
   end

   assign active_o = act_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= per_q)) else $error("frame count past period"); // R6
   AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !run_q) |=> (cnt_q == '0 && !act_q)) else $error("frame not restarted"); // R7
   AST_WID_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && per_q != '0) |-> (wid_q < per_q)) else $error("width not clamped"); // R8
   AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && run_i) |=> ($stable(per_q) && $stable(wid_q))) else $error("fields changed"); // R9
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (!act_q && cnt_q == '0)) else $error("idle not cleared"); // R11
   AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && run_i && !tick_i) |=> $stable(act_q)) else $error("pulse moved without tick"); // R12

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
   import fsg_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_clk_i,
   input  logic             src_ext_i,
   input  logic             gen_en_i,
   input  logic             fs_en_i,
   input  logic             fs_act_low_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] width_i,
   output logic             bclk_o,
   output logic             bclk_rise_o,
   output logic             bclk_fall_o,
   output logic             fsync_o
);

   logic      lvl_next;
   logic      bclk_int;
   fsg_edge_t edges;
   logic      fs_run;
   logic      pulse_act;

   fsg_clk_src #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_clk_i  (ext_clk_i),
      .src_ext_i  (src_ext_i),
      .bclk_cur_i (bclk_int),
      .lvl_next_o (lvl_next)
   );

   fsg_bclk u_bclk (
      .clk        (clk),
      .rst_n      (rst_n),
      .gen_en_i   (gen_en_i),
      .lvl_next_i (lvl_next),
      .bclk_o     (bclk_int),
      .edge_o     (edges)
   );

   assign fs_run = gen_en_i & fs_en_i;

   fsg_frame #(
      .CNT_W(CNT_W)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (fs_run),
      .tick_i   (edges.rise),
      .period_i (period_i),
      .width_i  (width_i),
      .active_o (pulse_act)
   );

   assign bclk_o      = bclk_int;
   assign bclk_rise_o = edges.rise;
   assign bclk_fall_o = edges.fall;
   assign fsync_o     = pulse_act ^ fs_act_low_i;

   AST_INT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en_i && !src_ext_i) |=> (bclk_int != $past(bclk_int))) else $error("no toggle"); // R2
   AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_run |=> (fsync_o == fs_act_low_i)) else $error("pulse while frame disabled"); // R5

endmodule

// File: tb/tb_frame_sync_gen.sv
module tb_frame_sync_gen;

   localparam int CNT_W = 8;
   localparam int NVEC  = 8;

   // {period field, width field, active-low, expected effective width}
   localparam logic [24:0] VEC [NVEC] = '{
      {8'd31, 8'd15, 1'b0, 8'd15},
      {8'd31, 8'd15, 1'b1, 8'd15},
      {8'd7,  8'd0,  1'b0, 8'd0 },
      {8'd5,  8'd9,  1'b0, 8'd4 },
      {8'd3,  8'd3,  1'b1, 8'd2 },
      {8'd0,  8'd0,  1'b0, 8'd0 },
      {8'd1,  8'd0,  1'b1, 8'd0 },
      {8'd12, 8'd11, 1'b0, 8'd11}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ext_clk = 1'b0;
   logic             src_ext = 1'b0;
   logic             gen_en = 1'b0;
   logic             fs_en = 1'b0;
   logic             act_low = 1'b0;
   logic [CNT_W-1:0] period = '0;
   logic [CNT_W-1:0] width = '0;
   logic             bclk_o;
   logic             bclk_rise_o;
   logic             bclk_fall_o;
   logic             fsync_o;

   always #10 clk = ~clk;

   frame_sync_gen #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_clk_i    (ext_clk),
      .src_ext_i    (src_ext),
      .gen_en_i     (gen_en),
      .fs_en_i      (fs_en),
      .fs_act_low_i (act_low),
      .period_i     (period),
      .width_i      (width),
      .bclk_o       (bclk_o),
      .bclk_rise_o  (bclk_rise_o),
      .bclk_fall_o  (bclk_fall_o),
      .fsync_o      (fsync_o)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   // Reference frame model (R6, R7, R8, R10, R12): pulse registered one edge after rise strobe
   bit               mdl_on = 0;
   int               mm = 0;
   bit               m_run = 0;
   bit               m_act = 0;
   int               m_cnt = 0;
   int               cur_p = 0;
   int               cur_w = 0;

   always @(negedge clk) begin
      if (mdl_on && (fsync_o !== (m_act ^ act_low))) mm++;
      if (!rst_n || !(gen_en && fs_en)) begin
         m_run = 0; m_act = 0; m_cnt = 0;
      end else if (!m_run) begin
         m_run = 1; m_act = 0; m_cnt = 0;
      end else if (bclk_rise_o) begin
         m_act = (m_cnt <= cur_w);
         m_cnt = (m_cnt == cur_p) ? 0 : m_cnt + 1;
      end
   end

   // Internal toggle and strobe watcher (R2)
   bit int_chk = 0;
   int int_mm = 0;
   bit prev_b = 0;
   always @(negedge clk) begin
      if (int_chk) begin
         if (bclk_o === prev_b) int_mm++;
         if (bclk_rise_o !== (bclk_o && !prev_b)) int_mm++;
         if (bclk_fall_o !== (!bclk_o && prev_b)) int_mm++;
      end
      prev_b = bclk_o;
   end

   // External lag watcher (R3) and strobe counter (R3, R4)
   bit ext_run = 0;
   int ext_div = 0;
   always @(posedge clk) begin
      #3;
      if (ext_run) begin
         ext_div++;
         if (ext_div == 4) begin
            ext_div = 0;
            ext_clk = ~ext_clk;
         end
      end
   end

   bit ext_chk = 0;
   int ext_mm = 0;
   bit p1 = 0, p2 = 0, p3 = 0;
   bit cnt_on = 0;
   int rise_n = 0;
   int fall_n = 0;
   always @(negedge clk) begin
      if (ext_chk && (bclk_o !== p3)) ext_mm++;
      p3 = p2; p2 = p1; p1 = ext_clk;
      if (cnt_on) begin
         if (bclk_rise_o) rise_n++;
         if (bclk_fall_o) fall_n++;
      end
   end

   task automatic arm(input int p, input int w, input bit pol, input int ew);
      fs_en = 0;
      step(3);
      period = p[CNT_W-1:0];
      width = w[CNT_W-1:0];
      act_low = pol;
      cur_p = p;
      cur_w = ew;
      mm = 0;
      fs_en = 1;
   endtask

   task automatic first_pulse(input string req);
      int guard = 0;
      check(fsync_o == act_low, req, fsync_o, act_low);
      while (!bclk_rise_o && guard < 20) begin
         step(1);
         guard++;
      end
      step(1);
      check(fsync_o == !act_low, req, fsync_o, !act_low);
   endtask

   initial begin
      // R1: reset state
      step(3);
      check(bclk_o == 0 && bclk_rise_o == 0 && bclk_fall_o == 0, "R1", bclk_o, 0);
      check(fsync_o == 0, "R1", fsync_o, 0);
      act_low = 1;
      #1;
      check(fsync_o == 1, "R1 R10", fsync_o, 1);
      act_low = 0;
      rst_n = 1;
      step(2);

      // R2: internal source toggling and strobes
      gen_en = 1;
      step(1);
      int_chk = 1;
      step(24);
      int_chk = 0;
      check(int_mm == 0, "R2", int_mm, 0);

      // R5: generator alone gives no pulse, either polarity
      mdl_on = 1;
      mm = 0;
      step(50);
      act_low = 1;
      step(50);
      check(mm == 0 && fsync_o == 1, "R5", mm, 0);
      act_low = 0;

      // Vector table: R6 R7 R8 R10 R12
      for (int i = 0; i < NVEC; i++) begin
         arm(int'(VEC[i][24:17]), int'(VEC[i][16:9]), VEC[i][8], int'(VEC[i][7:0]));
         step(8 * (int'(VEC[i][24:17]) + 1) + 40);
         check(mm == 0, "R6 R7 R8 R10 R12", mm, 0);
      end

      // R7: first pulse on the first rising strobe after enable
      fs_en = 0;
      act_low = 0;
      step(3);
      period = 8'd9; width = 8'd4; cur_p = 9; cur_w = 4;
      fs_en = 1;
      step(1);
      first_pulse("R7");

      // R9: field changes while running are ignored
      arm(7, 2, 0, 2);
      step(30);
      mm = 0;
      period = 8'd3;
      width = 8'd1;
      step(100);
      check(mm == 0, "R9", mm, 0);

      // R11 and R4: drop both enables, then restart
      gen_en = 0;
      fs_en = 0;
      step(2);
      check(bclk_o == 0 && fsync_o == 0, "R11", fsync_o, 0);
      rise_n = 0; fall_n = 0; cnt_on = 1;
      step(10);
      cnt_on = 0;
      check(rise_n + fall_n == 0, "R4", rise_n + fall_n, 0);
      period = 8'd9; width = 8'd4; cur_p = 9; cur_w = 4;
      gen_en = 1;
      fs_en = 1;
      step(1);
      first_pulse("R11");

      // R3: external source
      gen_en = 0;
      fs_en = 0;
      step(3);
      src_ext = 1;
      ext_run = 1;
      step(2);
      gen_en = 1;
      step(10);
      ext_mm = 0;
      rise_n = 0;
      ext_chk = 1;
      cnt_on = 1;
      step(80);
      ext_chk = 0;
      cnt_on = 0;
      check(ext_mm == 0, "R3", ext_mm, 0);
      check(rise_n >= 9 && rise_n <= 11, "R3", rise_n, 10);
      arm(3, 1, 0, 1);
      step(200);
      check(mm == 0, "R3 R6", mm, 0);

      // R1: reset while running returns to idle
      mdl_on = 0;
      rst_n = 0;
      #1;
      check(bclk_o == 0 && fsync_o == 0 && bclk_rise_o == 0, "R1", bclk_o, 0);
      step(2);

      finish_run();
   end

endmodule